// File: doc/BRIEF.md
# CPU Clock Rate-Change Sequencer

This block steps a CPU clock domain through a retune of its main PLL. Control logic raises `pre_req` before the PLL is reprogrammed and `post_req` after it has relocked. Each request comes with the old rate, the new rate, the rate of the alternate source, and the target divider words. The block then drives a single-cycle register-write port toward the clock-control registers. Between writes it polls the divider and mux status inputs. Every poll has a cycle-count limit.

Before the change, the block works out an interim divide ratio for the alternate source. With that ratio in force, the CPU clock never runs faster than the lower of the old and new rates while the mux sits on the alternate source. It then moves the mux to the alternate source and loads the target divider words. After the change, it returns the mux to the PLL and removes the interim ratio.

The state machine has these states: IDLE, CALC (iterative ratio search), SAFE_WR / SAFE_WAIT (interim ratio write and divider settle), ALT_WR / ALT_WAIT (mux to alternate, wait for status 2), DIV0_WR / DIV0_WAIT and DIV1_WR / DIV1_WAIT (target words), PLL_WR / PLL_WAIT (mux to PLL, wait for status 1), CLR_WR / CLR_WAIT (interim ratio removal) and DONE (one-cycle end marker).

The transitions are:
- IDLE→CALC on `pre_req`.
- IDLE→PLL_WR on `post_req`. `pre_req` wins if both are high.
- CALC→SAFE_WR when an interim ratio applies, otherwise CALC→ALT_WR.
- Each *_WR state moves to its *_WAIT state.
- Each *_WAIT state leaves on status match or timeout: SAFE→ALT_WR, ALT→DIV0_WR, DIV0→DIV1_WR when word 1 is enabled (else DONE), DIV1→DONE, PLL→CLR_WR, CLR→DONE.
- DONE→IDLE.

Top module: `cpuclk_switch_seq`

## Requirements
- R1: While reset is low and after it is released, `busy`, `done`, `reg_wr`, `err_timeout`, `err_busy` and `warn_ratio` are all 0.
- R2: An interim ratio is applied on a pre-change request exactly when the alternate rate exceeds the old rate or the old rate exceeds the new rate. Otherwise the sequence writes the mux first and then the target word 0, unmodified.
- R3: The interim field equals ceil(alt_rate / min(old_rate, new_rate)) − 1 and sits in bits [2:0] of divider word 0. A result of 8 or more, or a zero minimum rate, sets the sticky `warn_ratio` and uses field value 7.
- R4: The pre-change order is fixed:
  - write the interim ratio into divider word 0;
  - wait until the masked bits of `div0_status` are zero;
  - write the mux register with bit 0 = 1;
  - wait until `mux_status` equals 2;
  - write divider word 0 as the target word ORed with the interim pattern.
- R5: Divider word 1 is written with `tgt_div1`, followed by a wait for `div1_status` to read zero, only when `div1_en` was high at the request.
- R6: The post-change order is: write the mux register with bit 0 = 0, wait until `mux_status` equals 1, then write divider word 0 with bits [2:0] cleared. Every other bit of the last word written to divider word 0 is kept, except the debug field when debug forcing is on.
- R7: With `dbg_force` high and an interim ratio applied, bits [18:16] of divider word 0 read 111 in both the interim write and the target write. After the change, those bits are restored from `tgt_div0`.
- R8: Each wait ends after `TMO_CYCLES` cycles without a match. It then sets the sticky `err_timeout`, and the sequence continues with its next step.
- R9: `done` is a single-cycle pulse at the end of each sequence. `busy` is high from acceptance through the `done` cycle and low afterwards.
- R10: A request that arrives while `busy` is high produces no register write and sets the sticky `err_busy`.
- R11: `reg_wr` lasts one cycle per write. `reg_sel` is 0 for divider word 0, 1 for divider word 1 and 2 for the mux register. Waits after interim writes mask bits [2:0] (plus [18:16] when debug forcing is on). Waits after full word writes use every bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_req | input | 1 | Start the pre-change sequence |
| post_req | input | 1 | Start the post-change sequence |
| old_rate | input | RATE_W | Rate before the change |
| new_rate | input | RATE_W | Rate after the change |
| alt_rate | input | RATE_W | Alternate-source rate |
| tgt_div0 | input | DIV_W | Target divider word 0 |
| tgt_div1 | input | DIV_W | Target divider word 1 |
| div1_en | input | 1 | Enable the divider word 1 write |
| dbg_force | input | 1 | Force the debug-bus divider field during the switch |
| mux_status | input | 3 | Mux status: 1 PLL active, 2 alternate active |
| div0_status | input | DIV_W | Divider word 0 busy bits |
| div1_status | input | DIV_W | Divider word 1 busy bits |
| reg_wr | output | 1 | Register write strobe |
| reg_sel | output | 2 | Target register select |
| reg_wdata | output | DIV_W | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | End-of-sequence pulse |
| err_timeout | output | 1 | Sticky poll timeout |
| err_busy | output | 1 | Sticky request-while-busy |
| warn_ratio | output | 1 | Sticky interim ratio overflow |

## Verification
Each write leaves the block one cycle after the state machine enters its write state. The following wait then holds the next write back until a status sample taken at a clock edge matches. With a settle model of N cycles, the next write can come no sooner than N+2 cycles after the previous one, and the bench checks that gap against the cycle numbers it logs for each write. The interim-ratio search takes up to nine cycles, so the bench never expects results at fixed cycles. Instead, it waits for the `done` pulse, sampled at falling edges and bounded by a loop limit. It then compares the complete logged write sequence and the sticky flags. On the falling edge after `done`, it checks that both `done` and `busy` have dropped.

// File: rtl/cpuclk_seq_pkg.sv
package cpuclk_seq_pkg;
    typedef enum logic [1:0] {
        SEL_DIV0 = 2'd0,
        SEL_DIV1 = 2'd1,
        SEL_MUX  = 2'd2
    } reg_sel_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CALC, ST_SAFE_WR, ST_SAFE_WAIT, ST_ALT_WR, ST_ALT_WAIT,
        ST_DIV0_WR, ST_DIV0_WAIT, ST_DIV1_WR, ST_DIV1_WAIT,
        ST_PLL_WR, ST_PLL_WAIT, ST_CLR_WR, ST_CLR_WAIT, ST_DONE
    } state_e;

    localparam int         FIELD_W  = 3;
    localparam int         DBG_LSB  = 16;
    localparam logic [2:0] MUX_ON_PLL = 3'd1;
    localparam logic [2:0] MUX_ON_ALT = 3'd2;
endpackage

// File: rtl/cpuclk_safe_ratio.sv
module cpuclk_safe_ratio #(
    parameter int RATE_W  = 16,
    parameter int FIELD_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [RATE_W-1:0]  alt_rate,
    input  logic [RATE_W-1:0]  old_rate,
    input  logic [RATE_W-1:0]  new_rate,
    output logic               done,
    output logic               apply,
    output logic [FIELD_W-1:0] field,
    output logic               warn
);
    localparam int QMAX = 1 << FIELD_W;
    localparam int QW   = FIELD_W + 1;
    localparam int AW   = RATE_W + FIELD_W + 1;

    logic [RATE_W-1:0] min_in;
    logic [RATE_W-1:0] min_q;
    logic [RATE_W-1:0] alt_q;
    logic [AW-1:0]     acc_q;
    logic [QW-1:0]     q_q;
    logic              run_q;

    assign min_in = (old_rate < new_rate) ? old_rate : new_rate;

    // Smallest q with q*min >= alt, searched by repeated addition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_q <= '0; alt_q <= '0; acc_q <= '0; q_q <= '0; run_q <= 1'b0;
            done <= 1'b0; apply <= 1'b0; field <= '0; warn <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                min_q <= min_in;
                alt_q <= alt_rate;
                acc_q <= AW'(min_in);
                q_q   <= QW'(1);
                run_q <= 1'b1;
                warn  <= 1'b0;
                apply <= (alt_rate > old_rate) || (old_rate > new_rate);
            end else if (run_q) begin
                if (min_q == '0 || (acc_q < AW'(alt_q) && q_q == QW'(QMAX))) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                    warn  <= 1'b1;
                    field <= '1;
                end else if (acc_q >= AW'(alt_q)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                    field <= FIELD_W'(q_q - QW'(1));
                end else begin
                    acc_q <= acc_q + AW'(min_q);
                    q_q   <= q_q + QW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/cpuclk_poll_timer.sv
module cpuclk_poll_timer #(
    parameter int TMO_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic active,
    input  logic ok,
    output logic finish,
    output logic expired
);
    localparam int CW = $clog2(TMO_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    assign expired = active && !ok && (cnt_q == CW'(TMO_CYCLES - 1));
    assign finish  = active && (ok || expired);

    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (arm)                       cnt_q <= '0;
        else if (active && !ok && !expired) cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/cpuclk_switch_seq.sv
module cpuclk_switch_seq
    import cpuclk_seq_pkg::*;
#(
    parameter int RATE_W     = 16,
    parameter int DIV_W      = 32,
    parameter int TMO_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_req,
    input  logic              post_req,
    input  logic [RATE_W-1:0] old_rate,
    input  logic [RATE_W-1:0] new_rate,
    input  logic [RATE_W-1:0] alt_rate,
    input  logic [DIV_W-1:0]  tgt_div0,
    input  logic [DIV_W-1:0]  tgt_div1,
    input  logic              div1_en,
    input  logic              dbg_force,
    input  logic [2:0]        mux_status,
    input  logic [DIV_W-1:0]  div0_status,
    input  logic [DIV_W-1:0]  div1_status,
    output logic              reg_wr,
    output logic [1:0]        reg_sel,
    output logic [DIV_W-1:0]  reg_wdata,
    output logic              busy,
    output logic              done,
    output logic              err_timeout,
    output logic              err_busy,
    output logic              warn_ratio
);
    localparam logic [DIV_W-1:0] FIELD_M = DIV_W'((1 << FIELD_W) - 1);
    localparam logic [DIV_W-1:0] DBG_M   = FIELD_M << DBG_LSB;

    state_e            state_q, state_d;
    logic [DIV_W-1:0]  tgt0_q, tgt1_q, shadow_q, safe_q;
    logic              div1_en_q, dbg_q;
    logic [DIV_W-1:0]  smask;
    logic              sd_done, sd_apply, sd_warn;
    logic [FIELD_W-1:0] sd_field;
    logic              poll_active, poll_ok, poll_fin, poll_exp;
    logic              accept;

    assign accept = (state_q == ST_IDLE) && (pre_req || post_req);
    assign smask  = dbg_q ? (FIELD_M | DBG_M) : FIELD_M;

    cpuclk_safe_ratio #(.RATE_W(RATE_W), .FIELD_W(FIELD_W)) u_ratio (
        .clk(clk), .rst_n(rst_n), .start((state_q == ST_IDLE) && pre_req),
        .alt_rate(alt_rate), .old_rate(old_rate), .new_rate(new_rate),
        .done(sd_done), .apply(sd_apply), .field(sd_field), .warn(sd_warn)
    );

    cpuclk_poll_timer #(.TMO_CYCLES(TMO_CYCLES)) u_poll (
        .clk(clk), .rst_n(rst_n), .arm(reg_wr), .active(poll_active),
        .ok(poll_ok), .finish(poll_fin), .expired(poll_exp)
    );

    // Status condition for the current wait state.
    always_comb begin
        poll_active = 1'b1;
        poll_ok     = 1'b0;
        unique case (state_q)
            ST_SAFE_WAIT, ST_CLR_WAIT: poll_ok = (div0_status & smask) == '0;
            ST_ALT_WAIT:               poll_ok = mux_status == MUX_ON_ALT;
            ST_PLL_WAIT:               poll_ok = mux_status == MUX_ON_PLL;
            ST_DIV0_WAIT:              poll_ok = div0_status == '0;
            ST_DIV1_WAIT:              poll_ok = div1_status == '0;
            default:                   poll_active = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (pre_req) state_d = ST_CALC;
                          else if (post_req) state_d = ST_PLL_WR;
            ST_CALC:      if (sd_done) state_d = sd_apply ? ST_SAFE_WR : ST_ALT_WR;
            ST_SAFE_WR:   state_d = ST_SAFE_WAIT;
            ST_SAFE_WAIT: if (poll_fin) state_d = ST_ALT_WR;
            ST_ALT_WR:    state_d = ST_ALT_WAIT;
            ST_ALT_WAIT:  if (poll_fin) state_d = ST_DIV0_WR;
            ST_DIV0_WR:   state_d = ST_DIV0_WAIT;
            ST_DIV0_WAIT: if (poll_fin) state_d = div1_en_q ? ST_DIV1_WR : ST_DONE;
            ST_DIV1_WR:   state_d = ST_DIV1_WAIT;
            ST_DIV1_WAIT: if (poll_fin) state_d = ST_DONE;
            ST_PLL_WR:    state_d = ST_PLL_WAIT;
            ST_PLL_WAIT:  if (poll_fin) state_d = ST_CLR_WR;
            ST_CLR_WR:    state_d = ST_CLR_WAIT;
            ST_CLR_WAIT:  if (poll_fin) state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs driven purely from the current state.
    always_comb begin
        reg_wr    = 1'b0;
        reg_sel   = SEL_DIV0;
        reg_wdata = '0;
        unique case (state_q)
            ST_SAFE_WR: begin
                reg_wr = 1'b1; reg_wdata = (shadow_q & ~smask) | safe_q;
            end
            ST_ALT_WR: begin
                reg_wr = 1'b1; reg_sel = SEL_MUX; reg_wdata = DIV_W'(1);
            end
            ST_DIV0_WR: begin
                reg_wr = 1'b1; reg_wdata = tgt0_q | safe_q;
            end
            ST_DIV1_WR: begin
                reg_wr = 1'b1; reg_sel = SEL_DIV1; reg_wdata = tgt1_q;
            end
            ST_PLL_WR: begin
                reg_wr = 1'b1; reg_sel = SEL_MUX; reg_wdata = '0;
            end
            ST_CLR_WR: begin
                reg_wr = 1'b1;
                reg_wdata = (shadow_q & ~smask) | (dbg_q ? (tgt0_q & DBG_M) : '0);
            end
            default: ;
        endcase
    end

    assign busy = state_q != ST_IDLE;
    assign done = state_q == ST_DONE;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt0_q <= '0; tgt1_q <= '0; shadow_q <= '0; safe_q <= '0;
            div1_en_q <= 1'b0; dbg_q <= 1'b0;
            err_timeout <= 1'b0; err_busy <= 1'b0; warn_ratio <= 1'b0;
        end else begin
            if (accept) begin
                tgt0_q    <= tgt_div0;
                tgt1_q    <= tgt_div1;
                div1_en_q <= div1_en;
                dbg_q     <= dbg_force;
                safe_q    <= '0;
            end
            if (state_q == ST_CALC && sd_done && sd_apply)
                safe_q <= (dbg_q ? DBG_M : '0) | DIV_W'(sd_field);
            if (reg_wr && reg_sel == SEL_DIV0) shadow_q <= reg_wdata;
            if (busy && (pre_req || post_req)) err_busy <= 1'b1;
            if (poll_exp) err_timeout <= 1'b1;
            if (sd_done && sd_warn) warn_ratio <= 1'b1;
        end
    end
endmodule

// File: rtl/cpuclk_switch_seq_sva.sv
module cpuclk_switch_seq_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       pre_req,
    input logic       post_req,
    input logic       reg_wr,
    input logic [1:0] reg_sel,
    input logic       busy,
    input logic       done,
    input logic       err_timeout,
    input logic       err_busy,
    input logic       warn_ratio
);
    assert_wr_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);
    assert_sel_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> reg_sel != 2'd3);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    assert_done_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    assert_tmo_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |=> err_timeout);
    assert_busy_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (pre_req || post_req)) |=> err_busy);
    assert_busy_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_busy |=> err_busy);
    assert_warn_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        warn_ratio |=> warn_ratio);
endmodule

bind cpuclk_switch_seq cpuclk_switch_seq_sva u_sva (
    .clk(clk), .rst_n(rst_n), .pre_req(pre_req), .post_req(post_req),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .busy(busy), .done(done),
    .err_timeout(err_timeout), .err_busy(err_busy), .warn_ratio(warn_ratio)
);

// File: tb/sim_cpuclk_switch_seq.sv
`timescale 1ns/1ps
module sim_cpuclk_switch_seq;
    localparam int RW = 16;
    localparam int DW = 32;
    localparam int TMO = 20;
    localparam int BUSY_CYC = 3;
    localparam int MUX_CYC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pre_req = 1'b0, post_req = 1'b0;
    logic [RW-1:0] old_rate = '0, new_rate = '0, alt_rate = '0;
    logic [DW-1:0] tgt_div0 = '0, tgt_div1 = '0;
    logic div1_en = 1'b0, dbg_force = 1'b0;
    logic [2:0] mux_status;
    logic [DW-1:0] div0_status, div1_status;
    logic reg_wr;
    logic [1:0] reg_sel;
    logic [DW-1:0] reg_wdata;
    logic busy, done, err_timeout, err_busy, warn_ratio;

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 0;
    bit div_hang = 0;

    int nlog = 0;
    logic [1:0]    log_sel [16];
    logic [DW-1:0] log_dat [16];
    int            log_cyc [16];

    always #2.5 clk = ~clk;

    cpuclk_switch_seq #(.RATE_W(RW), .DIV_W(DW), .TMO_CYCLES(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .pre_req(pre_req), .post_req(post_req),
        .old_rate(old_rate), .new_rate(new_rate), .alt_rate(alt_rate),
        .tgt_div0(tgt_div0), .tgt_div1(tgt_div1), .div1_en(div1_en),
        .dbg_force(dbg_force), .mux_status(mux_status),
        .div0_status(div0_status), .div1_status(div1_status),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .busy(busy), .done(done), .err_timeout(err_timeout),
        .err_busy(err_busy), .warn_ratio(warn_ratio)
    );

    // Register/status model of the clock controller.
    int d0cnt = 0, d1cnt = 0, mcnt = 0;
    logic msel = 1'b0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            d0cnt <= 0; d1cnt <= 0; mcnt <= 0; msel <= 1'b0;
        end else begin
            if (reg_wr && reg_sel == 2'd0) d0cnt <= BUSY_CYC;
            else if (d0cnt != 0) d0cnt <= d0cnt - 1;
            if (reg_wr && reg_sel == 2'd1) d1cnt <= BUSY_CYC;
            else if (d1cnt != 0) d1cnt <= d1cnt - 1;
            if (reg_wr && reg_sel == 2'd2) begin mcnt <= MUX_CYC; msel <= reg_wdata[0]; end
            else if (mcnt != 0) mcnt <= mcnt - 1;
        end
    end
    assign div0_status = (div_hang || d0cnt != 0) ? 32'hF007_0007 : '0;
    assign div1_status = (d1cnt != 0) ? 32'h0000_000F : '0;
    assign mux_status  = (mcnt != 0) ? 3'd4 : (msel ? 3'd2 : 3'd1);

    always @(negedge clk) begin
        if (reg_wr && nlog < 16) begin
            log_sel[nlog] = reg_sel;
            log_dat[nlog] = reg_wdata;
            log_cyc[nlog] = cyc;
            nlog = nlog + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_wr(input string tag, input int i, input logic [1:0] s, input logic [31:0] d);
        chk({tag, " sel"}, (i < nlog) ? 32'(log_sel[i]) : 32'hFFFF_FFFF, 32'(s));
        chk({tag, " data"}, (i < nlog) ? log_dat[i] : 32'hDEAD_DEAD, d);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic setup(input int o, input int n, input int a, input logic [31:0] t0,
                         input logic [31:0] t1, input bit w1, input bit dbg);
        old_rate = RW'(o); new_rate = RW'(n); alt_rate = RW'(a);
        tgt_div0 = t0; tgt_div1 = t1; div1_en = w1; dbg_force = dbg;
    endtask

    task automatic wait_done(input string tag);
        int k = 0;
        bit seen = 0;
        while (k < 1000 && !seen) begin
            @(negedge clk);
            if (done) seen = 1;
            k++;
        end
        chk({tag, " R9 done pulse"}, 32'(seen), 1);
        @(negedge clk);
        chk({tag, " R9 done/busy low after"}, {30'b0, done, busy}, 0);
    endtask

    task automatic run(input bit post, input string tag);
        @(negedge clk);
        nlog = 0;
        if (post) post_req = 1'b1; else pre_req = 1'b1;
        @(negedge clk);
        pre_req = 1'b0; post_req = 1'b0;
        chk({tag, " R9 busy after accept"}, 32'(busy), 1);
        wait_done(tag);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 in reset", {26'b0, busy, done, reg_wr, err_timeout, err_busy, warn_ratio}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 after reset", {26'b0, busy, done, reg_wr, err_timeout, err_busy, warn_ratio}, 0);
    endtask

    // Up-shift with alternate faster than old: min 400, ceil(1000/400)=3, field 2.
    task automatic t_pre_up();
        setup(400, 800, 1000, 32'h1234_5670, 32'h0000_00AB, 1, 0);
        run(0, "pre_up");
        chk("R4 write count", nlog, 4);
        chk_wr("R3 safe write", 0, 2'd0, 32'h0000_0002);
        chk_wr("R4 mux to alt", 1, 2'd2, 32'h1);
        chk_wr("R4 div0 ORed", 2, 2'd0, 32'h1234_5672);
        chk_wr("R5 div1 written", 3, 2'd1, 32'h0000_00AB);
        chk("R11 safe wait before mux", 32'(log_cyc[1] - log_cyc[0] >= BUSY_CYC + 1), 1);
        chk("R4 mux wait before div0", 32'(log_cyc[2] - log_cyc[1] >= MUX_CYC + 1), 1);
        chk("R3 no warn", 32'(warn_ratio), 0);
    endtask

    task automatic t_post_plain();
        setup(400, 800, 1000, 32'h1234_5670, 32'h0, 0, 0);
        run(1, "post_plain");
        chk("R6 write count", nlog, 2);
        chk_wr("R6 mux to pll", 0, 2'd2, 32'h0);
        chk_wr("R6 clear keeps bits", 1, 2'd0, 32'h1234_5670);
        chk("R6 mux wait before clear", 32'(log_cyc[1] - log_cyc[0] >= MUX_CYC + 1), 1);
    endtask

    task automatic t_no_safe();
        setup(800, 1000, 500, 32'h0000_0003, 32'h55, 0, 0);
        run(0, "no_safe");
        chk("R2 no safe write count", nlog, 2);
        chk_wr("R2 mux first", 0, 2'd2, 32'h1);
        chk_wr("R2 div0 unmodified", 1, 2'd0, 32'h0000_0003);
        chk("R5 div1 skipped", 32'(nlog), 2);
        setup(800, 1000, 500, 32'h0000_0003, 32'h0, 0, 0);
        run(1, "no_safe_post");
        chk_wr("R6 clear field", 1, 2'd0, 32'h0000_0000);
    endtask

    // Down-shift with debug forcing: min 300, ceil(500/300)=2, field 1.
    task automatic t_down_dbg();
        setup(1000, 300, 500, 32'h0002_0440, 32'h5, 1, 1);
        run(0, "down_dbg");
        chk("R4 write count dbg", nlog, 4);
        chk_wr("R7 safe write dbg", 0, 2'd0, 32'h0007_0001);
        chk_wr("R7 div0 dbg forced", 2, 2'd0, 32'h0007_0441);
        chk_wr("R5 div1 dbg", 3, 2'd1, 32'h5);
        run(1, "down_dbg_post");
        chk_wr("R7 restore dbg field", 1, 2'd0, 32'h0002_0440);
    endtask

    // ceil(1000/100)=10 -> field would be 9: warn and clamp to 7.
    task automatic t_warn();
        chk("R3 warn clear before", 32'(warn_ratio), 0);
        setup(100, 200, 1000, 32'h0, 32'h0, 0, 0);
        run(0, "warn");
        chk_wr("R3 clamp field 7", 0, 2'd0, 32'h0002_0447);
        chk("R3 warn set", 32'(warn_ratio), 1);
        run(1, "warn_post");
    endtask

    task automatic t_busy_err();
        chk("R10 err_busy clear before", 32'(err_busy), 0);
        setup(400, 800, 1000, 32'h0000_0100, 32'h9, 1, 0);
        @(negedge clk);
        nlog = 0;
        pre_req = 1'b1;
        @(negedge clk);
        pre_req = 1'b0;
        repeat (3) @(negedge clk);
        post_req = 1'b1;
        @(negedge clk);
        post_req = 1'b0;
        wait_done("busy_err");
        chk("R10 err_busy set", 32'(err_busy), 1);
        chk("R10 ignored request no extra writes", nlog, 4);
        chk_wr("R10 no pll mux write", 1, 2'd2, 32'h1);
        run(1, "busy_err_post");
    endtask

    task automatic t_timeout();
        do_reset();
        chk("R8 timeout clear before", 32'(err_timeout), 0);
        div_hang = 1;
        setup(400, 800, 1000, 32'h0000_0100, 32'h2, 1, 0);
        run(0, "timeout");
        div_hang = 0;
        chk("R8 timeout flag", 32'(err_timeout), 1);
        chk("R8 sequence continues", nlog, 4);
        chk_wr("R8 div0 after timeout", 2, 2'd0, 32'h0000_0102);
        chk("R8 wait length", 32'(log_cyc[1] - log_cyc[0] >= TMO), 1);
    endtask

    initial begin
        t_reset();
        t_pre_up();
        t_post_plain();
        t_no_safe();
        t_down_dbg();
        t_warn();
        t_busy_err();
        t_timeout();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule